// File: doc/BRIEF.md
# Full-Period Pseudo-Random State Generator

This block is a shift-register pseudo-random generator. Its sequence covers every W-bit word, the all-zero word included. A plain maximal-length shift register skips zero and has a period of 2^W-1. Here an extra term in the feedback walks the register through zero and out again, so the period is exactly 2^W. The block is useful wherever every index of a power-of-two space must be reached, such as address or slot selection.

The generator has two control strobes. One copies a seed word into the register. The other advances the register by one step on each clock where it is high. The present register contents appear directly on the output word, with no extra pipeline stage. The output is continuously valid and has no handshake. There is no back-pressure: a consumer takes a new value by raising the advance strobe, and holds the current value by keeping both strobes low.

Top module: `zlfsr_gen`

## Requirements
- R1: While the asynchronous reset is high, the output word is 1 (only bit 0 set). The reset takes effect without waiting for a clock edge.
- R2: If the load strobe is high at a rising clock edge, the output shows the seed input from that edge on.
- R3: If the load and advance strobes are both high at the same edge, the load wins. The output becomes the seed and no step is taken.
- R4: If only the advance strobe is high at an edge, the output s becomes {s[W-2:0], f}. For W=12, f = s[11]^s[5]^s[3]^s[0], inverted when s[10:0] is all zero.
- R5: If both strobes are low at an edge, the output keeps its value.
- R6: Starting from any seed, 2^W consecutive steps visit each of the 2^W words exactly once, and the register is then back at the seed.
- R7: From the word with only the top bit set, one step gives zero. From zero, one step gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| arst_i | input | 1 | Asynchronous reset, active high |
| load_i | input | 1 | Seed-load strobe |
| seed_i | input | W | Seed word |
| step_i | input | 1 | Advance strobe |
| state_o | output | W | Present register contents |

## Verification
The assertions assume that both strobes and the seed are known values, sampled at the rising edge. They also assume that W is one of the widths in the tap table (3 to 16). The reset check assumes reset was raised before the first clock edge. The stimulus changes every input on the falling edge, and it raises and releases reset away from the rising edge. The full-period walk keeps the advance strobe high and the load strobe low for 2^W cycles, so no load breaks the cycle being counted.

// File: rtl/zlfsr_pkg.sv
`timescale 1ns/1ps
package zlfsr_pkg;
  typedef enum logic [1:0] {ZL_HOLD, ZL_LOAD, ZL_STEP} zl_op_e;

  // Tap mask of a maximal-length polynomial; bit k-1 set for tap k.
  function automatic logic [31:0] tap_mask(input int w);
    logic [31:0] m;
    m = '0;
    case (w)
      3:  begin m[2] = 1'b1; m[1] = 1'b1; end
      4:  begin m[3] = 1'b1; m[2] = 1'b1; end
      5:  begin m[4] = 1'b1; m[2] = 1'b1; end
      6:  begin m[5] = 1'b1; m[4] = 1'b1; end
      7:  begin m[6] = 1'b1; m[5] = 1'b1; end
      8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
      9:  begin m[8] = 1'b1; m[4] = 1'b1; end
      10: begin m[9] = 1'b1; m[6] = 1'b1; end
      11: begin m[10] = 1'b1; m[8] = 1'b1; end
      12: begin m[11] = 1'b1; m[5] = 1'b1; m[3] = 1'b1; m[0] = 1'b1; end
      13: begin m[12] = 1'b1; m[3] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
      14: begin m[13] = 1'b1; m[4] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
      15: begin m[14] = 1'b1; m[13] = 1'b1; end
      16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/zlfsr_next.sv
`timescale 1ns/1ps
module zlfsr_next #(
  parameter int W = 12
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  import zlfsr_pkg::*;
  localparam logic [31:0]  MASK32 = tap_mask(W);
  localparam logic [W-1:0] TAPS   = MASK32[W-1:0];

  logic lin_fb;
  logic low_zero;

  always_comb begin
    lin_fb   = ^(cur_i & TAPS);
    // Only the outgoing top bit may be set: flip feedback to splice in zero.
    low_zero = ~|cur_i[W-2:0];
    nxt_o    = {cur_i[W-2:0], lin_fb ^ low_zero};
  end
endmodule

// File: rtl/zlfsr_state.sv
`timescale 1ns/1ps
module zlfsr_state #(
  parameter int W = 12,
  parameter logic [W-1:0] RESET_VAL = 1
) (
  input  logic         clk_i,
  input  logic         arst_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] seed_i,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] q_o
);
  import zlfsr_pkg::*;
  zl_op_e op;

  always_comb begin
    if (load_i)      op = ZL_LOAD;
    else if (step_i) op = ZL_STEP;
    else             op = ZL_HOLD;
  end

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      q_o <= RESET_VAL;
    end else begin
      case (op)
        ZL_LOAD: q_o <= seed_i;
        ZL_STEP: q_o <= nxt_i;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/zlfsr_gen.sv
`timescale 1ns/1ps
module zlfsr_gen #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         arst_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] RESET_VAL = W'(1);

  logic [W-1:0] cur;
  logic [W-1:0] nxt;

  zlfsr_next #(.W(W)) u_next (
    .cur_i (cur),
    .nxt_o (nxt)
  );

  zlfsr_state #(.W(W), .RESET_VAL(RESET_VAL)) u_state (
    .clk_i  (clk_i),
    .arst_i (arst_i),
    .load_i (load_i),
    .step_i (step_i),
    .seed_i (seed_i),
    .nxt_i  (nxt),
    .q_o    (cur)
  );

  assign state_o = cur;
endmodule

// File: rtl/zlfsr_gen_chk.sv
`timescale 1ns/1ps
module zlfsr_gen_chk #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         arst_i,
  input logic         load_i,
  input logic [W-1:0] seed_i,
  input logic         step_i,
  input logic [W-1:0] state_o
);
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

  p_reset_value_r1: assert property (@(posedge clk_i)
    arst_i |-> state_o == W'(1));

  p_load_seed_r2: assert property (@(posedge clk_i) disable iff (arst_i)
    (load_i && !step_i) |=> state_o == $past(seed_i));

  p_load_wins_r3: assert property (@(posedge clk_i) disable iff (arst_i)
    (load_i && step_i) |=> state_o == $past(seed_i));

  p_step_shift_r4: assert property (@(posedge clk_i) disable iff (arst_i)
    (step_i && !load_i) |=> state_o[W-1:1] == $past(state_o[W-2:0]));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (arst_i)
    (!step_i && !load_i) |=> $stable(state_o));

  p_enter_zero_r7: assert property (@(posedge clk_i) disable iff (arst_i)
    (step_i && !load_i && state_o == TOP_ONLY) |=> state_o == '0);

  p_leave_zero_r7: assert property (@(posedge clk_i) disable iff (arst_i)
    (step_i && !load_i && state_o == '0) |=> state_o == W'(1));
endmodule

bind zlfsr_gen zlfsr_gen_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .arst_i  (arst_i),
  .load_i  (load_i),
  .seed_i  (seed_i),
  .step_i  (step_i),
  .state_o (state_o)
);

// File: tb/zlfsr_gen_test.sv
`timescale 1ns/1ps
module zlfsr_gen_test;
  localparam int W = 12;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         arst = 1'b0;
  logic         load = 1'b0;
  logic         step = 1'b0;
  logic [W-1:0] seed = '0;
  logic [W-1:0] state;

  int checks = 0;
  int failures = 0;
  int expv = 1;
  bit seen [N];

  always #2.5 clk = ~clk;

  zlfsr_gen #(.W(W)) uut (
    .clk_i(clk), .arst_i(arst), .load_i(load),
    .seed_i(seed), .step_i(step), .state_o(state)
  );

  // Behavioural model of one step (R4): taps 11,5,3,0 plus zero splice.
  function automatic int model_step(input int s);
    int par;
    par = ((s >> 11) ^ (s >> 5) ^ (s >> 3) ^ s) & 1;
    if ((s % 2048) == 0) par = par ^ 1;
    return (s * 2 + par) % N;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic cyc(input bit ld, input bit st, input int sd, input string req);
    load = ld; step = st; seed = W'(sd);
    @(posedge clk);
    if (ld) expv = sd;
    else if (st) expv = model_step(expv);
    @(negedge clk);
    check(int'(state) == expv, req, int'(state), expv);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1 arst = 1'b1;
    repeat (3) @(negedge clk);
    check(int'(state) == 1, "R1", int'(state), 1);
    #1 arst = 1'b0;
    expv = 1;
    @(negedge clk);
    check(int'(state) == 1, "R1", int'(state), 1);

    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 'h3C3, "R5");
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 0, "R4");
    cyc(1'b1, 1'b0, 'hABC, "R2");
    cyc(1'b0, 1'b0, 'h111, "R5");
    cyc(1'b1, 1'b1, 'h123, "R3");
    cyc(1'b1, 1'b0, 'h800, "R2");
    cyc(1'b0, 1'b1, 0, "R7");
    check(int'(state) == 0, "R7", int'(state), 0);
    cyc(1'b0, 1'b1, 0, "R7");
    check(int'(state) == 1, "R7", int'(state), 1);
    cyc(1'b1, 1'b0, 0, "R2");
    cyc(1'b0, 1'b1, 0, "R7");

    // Full period walk from seed 5A5 (R6).
    cyc(1'b1, 1'b0, 'h5A5, "R2");
    for (int i = 0; i < N; i++) seen[i] = 1'b0;
    for (int i = 0; i < N; i++) begin
      cyc(1'b0, 1'b1, 0, "R4");
      check(!seen[int'(state)], "R6", int'(state), -1);
      seen[int'(state)] = 1'b1;
    end
    check(int'(state) == 'h5A5, "R6", int'(state), 'h5A5);

    // Mixed strobes.
    for (int i = 0; i < 300; i++) begin
      automatic int r = int'($urandom_range(0, 3));
      automatic int sd = int'($urandom_range(0, N - 1));
      case (r)
        0: cyc(1'b0, 1'b0, sd, "R5");
        1: cyc(1'b1, 1'b0, sd, "R2");
        2: cyc(1'b1, 1'b1, sd, "R3");
        default: cyc(1'b0, 1'b1, sd, "R4");
      endcase
    end

    // Asynchronous reset mid-run, away from the edge (R1).
    cyc(1'b1, 1'b0, 'hFFF, "R2");
    #1 arst = 1'b1;
    #0.5;
    check(int'(state) == 1, "R1", int'(state), 1);
    @(negedge clk);
    #1 arst = 1'b0;
    expv = 1;
    cyc(1'b0, 1'b0, 0, "R5");
    cyc(1'b0, 1'b1, 0, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule